// File: doc/BRIEF.md
# Saturating Dual Accumulator with Overflow Status

This block keeps two 40-bit signed accumulators, A and B, and feeds them through a single shared adder/subtracter. On each valid operation a 40-bit sign-extended operand is added to or subtracted from the selected accumulator, or from zero when the zero-source option is set. The result, after optional saturation, is written back into that same accumulator. Each 40-bit value is a 1.31 fraction widened by eight guard bits at the top.

Each accumulator has its own saturation enable. One mode input picks where the clamp happens. The wide mode clamps only when the 40-bit range itself would wrap. The narrow mode clamps to the 32-bit signed range. Each accumulator reports two flags. A guard flag shows that the value no longer fits in 1.31. A sticky saturation flag records a clamp or a catastrophic wrap. The block also gives OR summaries of both pairs and a trap request, built from the guard flags and from catastrophic overflow events.

Top module: `dsp_sat_accum`

## Requirements
- R1: On a valid operation with zero-source off and subtract off, the selected accumulator (op_dst_i 0 = A, 1 = B) becomes its old value plus operand_i, modulo 2^40 when no saturation applies.
- R2: With op_sub_i = 1 the selected accumulator becomes its old value minus operand_i, computed as the operand complement plus a carry-in of one.
- R3: With op_zero_i = 1 the old accumulator value is replaced by zero as the adder source, so the result is +operand_i or -operand_i.
- R4: On every operation that targets it, the accumulator's guard flag (oa_o for A, ob_o for B) is set exactly when bits 39 to 31 of the loaded value are not all equal. The exception is narrow-mode saturation, where it is always cleared.
- R5: With saturation on and sat_mode40_i = 1, a result that overflows bit 39 loads 0x7FFFFFFFFF if the true sum is positive, or 0x8000000000 if it is negative, and sets that accumulator's saturation flag.
- R6: With saturation on and sat_mode40_i = 0, a true result outside the 32-bit signed range loads 0x007FFFFFFF or 0xFF80000000, depending on its sign, and sets the saturation flag. The guard flag is 0 after such an operation.
- R7: With saturation off for the target, a bit-39 overflow leaves the wrapped 40-bit result in place and still sets the saturation flag.
- R8: Saturation flags are sticky. Only clr_sat_i clears them, and it may do so with or without a valid operation. When a clear and a new saturation event fall on the same edge, the new event wins.
- R9: oab_o equals oa_o OR ob_o, and sab_o equals sa_o OR sb_o.
- R10: trap_o is high when ovf_trap_en_i is high and either guard flag is set. It is also high after a valid operation that overflowed bit 39 while cat_trap_en_i was high, and it stays high until the next valid operation.
- R11: Without op_valid_i, both accumulators and both guard flags hold their values.
- R12: An operation changes only the selected accumulator and its flags. The other accumulator keeps its value and flags.
- R13: After reset both accumulators are zero, and all flags and trap_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Perform an operation this cycle |
| op_sub_i | input | 1 | 1 = subtract operand, 0 = add |
| op_zero_i | input | 1 | Use zero in place of the accumulator as the adder source |
| op_dst_i | input | 1 | Target accumulator: 0 = A, 1 = B |
| operand_i | input | 40 | Sign-extended operand |
| sat_en_a_i | input | 1 | Saturation enable for A |
| sat_en_b_i | input | 1 | Saturation enable for B |
| sat_mode40_i | input | 1 | 1 = 40-bit saturation, 0 = 32-bit saturation |
| ovf_trap_en_i | input | 1 | Trap on guard overflow |
| cat_trap_en_i | input | 1 | Trap on bit-39 overflow |
| clr_sat_i | input | 1 | Clear both sticky saturation flags |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| oa_o | output | 1 | Guard overflow flag of A |
| ob_o | output | 1 | Guard overflow flag of B |
| sa_o | output | 1 | Sticky saturation flag of A |
| sb_o | output | 1 | Sticky saturation flag of B |
| oab_o | output | 1 | oa_o OR ob_o |
| sab_o | output | 1 | sa_o OR sb_o |
| trap_o | output | 1 | Trap request |

## Verification
The assertions assume that the operand is a properly sign-extended 40-bit value. They also assume that the control inputs stay stable while the clock edge samples them. The stimulus changes every input only on the falling edge.

The zero-source check expects the loaded value to equal the operand exactly. For that reason the stimulus saturates an accumulator only after preloading it, and it never applies zero-source to the most negative operand while saturation is off.

The narrow-mode range check assumes the mode and enable inputs do not change in the same cycle as the operation they qualify. The stimulus holds them steady across each operation.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;
  parameter int unsigned ACC_W_DEF = 40;
  parameter int unsigned LOW_W_DEF = 32;
  parameter int unsigned NUM_ACC   = 2;

  typedef struct packed {
    logic guard_ovf;
    logic sat_set;
    logic top_ovf;
  } acc_flags_t;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] opnd_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         top_ovf_o,
  output logic         neg_o
);
  logic [W:0] ext_a, ext_b, total;

  assign ext_a = {src_i[W-1], src_i};
  assign ext_b = sub_i ? ~{opnd_i[W-1], opnd_i} : {opnd_i[W-1], opnd_i};
  assign total = ext_a + ext_b + {{W{1'b0}}, sub_i};

  assign sum_o     = total[W-1:0];
  // carry into the top bit differs from the carry out of it
  assign top_ovf_o = total[W] ^ total[W-1];
  assign neg_o     = total[W];
endmodule

// File: rtl/acc_saturate.sv
module acc_saturate
  import dsp_acc_pkg::*;
#(
  parameter int unsigned W     = 40,
  parameter int unsigned LOW_W = 32
) (
  input  logic [W-1:0] sum_i,
  input  logic         top_ovf_i,
  input  logic         neg_i,
  input  logic         sat_en_i,
  input  logic         mode_wide_i,
  output logic [W-1:0] res_o,
  output acc_flags_t   flags_o
);
  localparam int unsigned GW = W - LOW_W + 1;
  localparam logic [W-1:0] MAX_WIDE = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_WIDE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_LOW  = {{GW{1'b0}}, {(LOW_W-1){1'b1}}};
  localparam logic [W-1:0] MIN_LOW  = {{GW{1'b1}}, {(LOW_W-1){1'b0}}};

  logic [GW-1:0] sum_top, res_top;
  logic          low_ovf;

  assign sum_top = sum_i[W-1:LOW_W-1];
  assign low_ovf = top_ovf_i | ~((&sum_top) | ~(|sum_top));
  assign res_top = res_o[W-1:LOW_W-1];

  always_comb begin
    res_o           = sum_i;
    flags_o.sat_set = top_ovf_i;
    if (sat_en_i && mode_wide_i) begin
      if (top_ovf_i) res_o = neg_i ? MIN_WIDE : MAX_WIDE;
    end else if (sat_en_i) begin
      flags_o.sat_set = low_ovf;
      if (low_ovf) res_o = neg_i ? MIN_LOW : MAX_LOW;
    end
    flags_o.guard_ovf = (sat_en_i && !mode_wide_i) ? 1'b0
                      : ~((&res_top) | ~(|res_top));
    flags_o.top_ovf   = top_ovf_i;
  end
endmodule

// File: rtl/acc_lane.sv
module acc_lane
  import dsp_acc_pkg::*;
#(
  parameter int unsigned W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic         clr_i,
  input  logic [W-1:0] res_i,
  input  acc_flags_t   flags_i,
  output logic [W-1:0] acc_o,
  output logic         guard_o,
  output logic         sat_o
);
  logic [W-1:0] acc_q;
  logic         guard_q, sat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      guard_q <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      if (upd_i) begin
        acc_q   <= res_i;
        guard_q <= flags_i.guard_ovf;
      end
      sat_q <= (sat_q & ~clr_i) | (upd_i & flags_i.sat_set);
    end
  end

  assign acc_o   = acc_q;
  assign guard_o = guard_q;
  assign sat_o   = sat_q;

  a_r8_sat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_q && !clr_i) |=> sat_q);

  a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(acc_q) && $stable(guard_q)));
endmodule

// File: rtl/dsp_sat_accum.sv
module dsp_sat_accum
  import dsp_acc_pkg::*;
#(
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned LOW_W = LOW_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic             op_sub_i,
  input  logic             op_zero_i,
  input  logic             op_dst_i,
  input  logic [ACC_W-1:0] operand_i,
  input  logic             sat_en_a_i,
  input  logic             sat_en_b_i,
  input  logic             sat_mode40_i,
  input  logic             ovf_trap_en_i,
  input  logic             cat_trap_en_i,
  input  logic             clr_sat_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic             oa_o,
  output logic             ob_o,
  output logic             sa_o,
  output logic             sb_o,
  output logic             oab_o,
  output logic             sab_o,
  output logic             trap_o
);
  logic [ACC_W-1:0]   acc_q [NUM_ACC];
  logic [NUM_ACC-1:0] guard_q, sat_q, sat_en;
  logic [ACC_W-1:0]   src, sum, res;
  logic               top_ovf, neg, cat_q;
  acc_flags_t         flags;

  assign sat_en = {sat_en_b_i, sat_en_a_i};
  assign src    = op_zero_i ? '0 : acc_q[op_dst_i];

  acc_addsub #(.W(ACC_W)) u_addsub (
    .src_i(src), .opnd_i(operand_i), .sub_i(op_sub_i),
    .sum_o(sum), .top_ovf_o(top_ovf), .neg_o(neg)
  );

  acc_saturate #(.W(ACC_W), .LOW_W(LOW_W)) u_sat (
    .sum_i(sum), .top_ovf_i(top_ovf), .neg_i(neg),
    .sat_en_i(sat_en[op_dst_i]), .mode_wide_i(sat_mode40_i),
    .res_o(res), .flags_o(flags)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_lane
    acc_lane #(.W(ACC_W)) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .upd_i(op_valid_i && (int'(op_dst_i) == g)),
      .clr_i(clr_sat_i), .res_i(res), .flags_i(flags),
      .acc_o(acc_q[g]), .guard_o(guard_q[g]), .sat_o(sat_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cat_q <= 1'b0;
    else if (op_valid_i) cat_q <= flags.top_ovf & cat_trap_en_i;
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign oa_o    = guard_q[0];
  assign ob_o    = guard_q[1];
  assign sa_o    = sat_q[0];
  assign sb_o    = sat_q[1];
  assign oab_o   = |guard_q;
  assign sab_o   = |sat_q;
  assign trap_o  = (ovf_trap_en_i & (|guard_q)) | cat_q;

  a_r6_narrow_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_dst_i && sat_en_a_i && !sat_mode40_i) |=>
      (((&acc_a_o[ACC_W-1:LOW_W-1]) || !(|acc_a_o[ACC_W-1:LOW_W-1])) && !oa_o));

  a_r3_zero_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_zero_i && !op_sub_i && op_dst_i && !sat_en_b_i) |=>
      (acc_b_o == $past(operand_i)));

  a_r10_trap_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !ovf_trap_en_i) |-> $past(cat_trap_en_i || !op_valid_i));
endmodule

// File: tb/dsp_sat_accum_tb_top.sv
`timescale 1ns/1ps
module dsp_sat_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 0, op_sub = 0, op_zero = 0, op_dst = 0;
  logic [39:0] operand = '0;
  logic        sen_a = 0, sen_b = 0, wide = 0, oten = 0, cten = 0, clr = 0;
  logic [39:0] acc_a, acc_b;
  logic        oa, ob, sa, sb, oab, sab, trap;

  always #2.5 clk = ~clk;

  dsp_sat_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_sub_i(op_sub),
    .op_zero_i(op_zero), .op_dst_i(op_dst), .operand_i(operand),
    .sat_en_a_i(sen_a), .sat_en_b_i(sen_b), .sat_mode40_i(wide),
    .ovf_trap_en_i(oten), .cat_trap_en_i(cten), .clr_sat_i(clr),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .oa_o(oa), .ob_o(ob), .sa_o(sa),
    .sb_o(sb), .oab_o(oab), .sab_o(sab), .trap_o(trap)
  );

  typedef struct {
    logic [39:0] a, b;
    logic oa, ob, sa, sb, trap;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0, n_errors = 0;
  bit   finished = 0;

  logic [39:0] m_a = '0, m_b = '0;
  bit m_oa = 0, m_ob = 0, m_sa = 0, m_sb = 0, m_cat = 0;

  function automatic longint sx(logic [39:0] x);
    return $signed({{24{x[39]}}, x});
  endfunction

  function automatic bit fits(longint v, int n);
    return (v >= -(64'sd1 <<< (n-1))) && (v <= (64'sd1 <<< (n-1)) - 1);
  endfunction

  task automatic push_exp(string tag);
    exp_t e;
    e.a = m_a; e.b = m_b; e.oa = m_oa; e.ob = m_ob; e.sa = m_sa; e.sb = m_sb;
    e.trap = (oten && (m_oa || m_ob)) || m_cat;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_op(bit dst, bit sub, bit zero, logic [39:0] opnd, bit sen,
                       bit wmode, bit ot, bit ct, string tag);
    longint src, t;
    logic [39:0] res;
    bit ov39, sset, g;
    @(negedge clk);
    op_valid = 1; op_dst = dst; op_sub = sub; op_zero = zero; operand = opnd;
    sen_a = sen; sen_b = sen; wide = wmode; oten = ot; cten = ct; clr = 0;
    src  = zero ? 64'sd0 : sx(dst ? m_b : m_a);
    t    = sub ? src - sx(opnd) : src + sx(opnd);
    ov39 = !fits(t, 40);
    res  = t[39:0];
    sset = ov39;
    if (sen && wmode) begin
      if (ov39) res = (t < 0) ? 40'h80_0000_0000 : 40'h7F_FFFF_FFFF;
    end else if (sen) begin
      sset = !fits(t, 32);
      if (sset) res = (t < 0) ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
    end
    g = (sen && !wmode) ? 1'b0 : !fits(sx(res), 32);
    if (dst) begin m_b = res; m_ob = g; m_sb = m_sb | sset; end
    else     begin m_a = res; m_oa = g; m_sa = m_sa | sset; end
    m_cat = ov39 && ct;
    push_exp(tag);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic do_idle(bit c, string tag);
    @(negedge clk);
    op_valid = 0; clr = c;
    operand = 40'hAB_CDEF_0123; op_zero = 0; op_sub = 1;
    if (c) begin m_sa = 0; m_sb = 0; end
    push_exp(tag);
    @(negedge clk);
    clr = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        if (acc_a !== e.a || acc_b !== e.b || oa !== e.oa || ob !== e.ob ||
            sa !== e.sa || sb !== e.sb || oab !== (e.oa | e.ob) ||
            sab !== (e.sa | e.sb) || trap !== e.trap) begin
          n_errors++;
          $display("FAIL %s: got a=%h b=%h oa=%b ob=%b sa=%b sb=%b oab=%b sab=%b trap=%b exp a=%h b=%h oa=%b ob=%b sa=%b sb=%b oab=%b sab=%b trap=%b",
                   e.tag, acc_a, acc_b, oa, ob, sa, sb, oab, sab, trap,
                   e.a, e.b, e.oa, e.ob, e.sa, e.sb, e.oa | e.ob, e.sa | e.sb, e.trap);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    n_checks++;
    if (acc_a !== '0 || acc_b !== '0 || oa || ob || sa || sb || oab || sab || trap) begin
      n_errors++;
      $display("FAIL R13 reset: got a=%h b=%h flags=%b%b%b%b trap=%b exp zeros",
               acc_a, acc_b, oa, ob, sa, sb, trap);
    end
    rst_n = 1'b1;
    // dst, sub, zero, operand, sen, wide, oten, cten
    do_op(0, 0, 1, 40'h00_0000_1234, 0, 1, 0, 0, "R3 zero-source load A");
    do_op(0, 0, 0, 40'h00_0000_0100, 0, 1, 0, 0, "R1 add to A");
    do_op(0, 1, 0, 40'h00_0000_0334, 0, 1, 0, 0, "R2 subtract from A");
    do_op(0, 1, 1, 40'h00_0000_0005, 0, 1, 0, 0, "R3 zero-source negate into A");
    do_op(1, 0, 1, 40'h7F_FFFF_FFFF, 1, 1, 0, 0, "R4 R12 guard flag on B, A untouched");
    do_op(1, 0, 0, 40'h00_0000_0001, 1, 1, 0, 0, "R5 wide positive clamp on B");
    do_op(1, 0, 1, 40'h00_0000_0010, 1, 1, 0, 0, "R8 sticky SB after normal op, R9");
    do_idle(1, "R8 clear sticky flags");
    do_idle(0, "R11 idle holds state");
    do_op(1, 0, 1, 40'h80_0000_0000, 1, 1, 0, 0, "R4 preload B most negative");
    do_op(1, 1, 0, 40'h00_0000_0001, 1, 1, 0, 0, "R5 wide negative clamp on B");
    do_idle(1, "R8 clear after negative clamp");
    do_op(0, 0, 1, 40'h00_7FFF_FFFF, 1, 0, 0, 0, "R6 preload A at 1.31 max");
    do_op(0, 0, 0, 40'h00_0000_0001, 1, 0, 0, 0, "R6 narrow positive clamp, OA low");
    do_op(0, 0, 1, 40'hFF_8000_0000, 1, 0, 0, 0, "R6 preload A at 1.31 min");
    do_op(0, 1, 0, 40'h00_0000_0005, 1, 0, 0, 0, "R6 narrow negative clamp");
    do_op(1, 0, 1, 40'h00_0000_0001, 1, 0, 0, 0, "R12 B op leaves A flags");
    do_idle(1, "R8 clear both");
    do_op(0, 0, 1, 40'h7F_FFFF_FFFF, 0, 1, 0, 0, "R7 preload A no saturation");
    do_op(0, 0, 0, 40'h00_0000_0002, 0, 1, 0, 0, "R7 wrap with SA set");
    do_idle(0, "R11 hold after wrap");
    do_op(1, 0, 1, 40'h00_0000_0003, 0, 1, 1, 0, "R10 guard trap from OA");
    do_op(0, 0, 1, 40'h00_0000_0004, 0, 1, 0, 1, "R10 no trap without overflow");
    do_op(0, 0, 0, 40'h7F_FFFF_FFFF, 0, 1, 0, 1, "R10 catastrophic trap");
    do_idle(0, "R10 trap held while idle");
    do_op(0, 0, 1, 40'h00_0000_0004, 0, 1, 0, 1, "R10 trap drops on next op");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule